// File: doc/BRIEF.md
# Reconfigurable Slot Swap Sequencer

This controller walks one reconfigurable region through the swap of its resident module. Software or a static-side master raises a swap command with a 2-bit module number. If a module is resident, the sequencer first asks it to finish its in-flight work and waits for its acknowledge. It then cuts the static side off with an isolation signal and sends a short three-beat command burst to an external bitstream loader. When the loader signals completion, the new module is held in reset under isolation, then released, and only then is isolation dropped and the slot marked ready.

Besides swaps, the slot can be emptied with an unload command, and a pending swap or unload can be withdrawn until the resident module acknowledges. Any command that conflicts with the present state is refused with a one-cycle error pulse and a reason code, and leaves the sequence untouched. A module that never acknowledges is abandoned after a programmable wait, without ever isolating it.

The loader command interface is valid/ready. `ld_valid` rises only while the burst is being issued and, once high, stays high with `ld_word` unchanged until a cycle with `ld_ready` high; a beat is taken on each clock edge where both are high. All other pins are plain level or single-cycle pulse signals.

Top module: `slot_swap_ctrl`

## Requirements
- R1: During and right after reset the slot is empty: `isolate`=1, `slot_loaded`=0, `rm_req`=0, `ld_valid`=0, `rm_rst`=0, `slot_ready`=0, `feed_en`=0, `err_flag`=0.
- R2: A swap accepted while a module is resident raises `rm_req` the next cycle and holds it until `rm_ack`; `feed_en` stays 1 while waiting and is 0 in any cycle where `rm_req` and `rm_ack` are both high.
- R3: `isolate` rises exactly one cycle after the cycle in which `rm_ack` was seen with `rm_req` high, and `feed_en` is never 1 while `isolate` is 1.
- R4: The load burst is three beats with the 2-bit tag in `ld_word[CMD_W-1:CMD_W-2]`: tag 01 carries the module number, tag 10 carries number × BASE_STRIDE, tag 11 carries IMG_WORDS, each payload zero-extended in the low bits; a beat held off by `ld_ready`=0 stays valid and stable.
- R5: The cycle after `ld_done` is seen while waiting for the loader, `rm_rst` goes high for exactly RST_CYC cycles with `isolate` high throughout; `ld_done` at any other time has no effect.
- R6: `rm_rst` falls one cycle before `isolate` falls; when `isolate` falls, `slot_ready`=1, `slot_loaded`=1 and `slot_id` equals the requested number.
- R7: A swap accepted while the slot is empty skips the handshake: the next cycle `ld_valid`=1 and `rm_req`=0, with `isolate` kept high.
- R8: An accepted unload runs the handshake, then leaves the slot empty with `isolate` held at 1 and no load burst; an unload while the slot is empty is refused with code 2.
- R9: A swap or unload arriving while a sequence is running is refused with code 1 one cycle later, and the running sequence continues with its original target.
- R10: A cancel while `rm_req` is high and `rm_ack` low drops `rm_req` the next cycle and returns to idle with the old module still resident and not isolated, without error; a cancel at any other time, including the cycle `rm_ack` is seen, is refused with code 2.
- R11: If no `rm_ack` arrives within ACK_TMO cycles of `rm_req`, `rm_req` drops, `err_code`=3 pulses, `isolate` stays 0 and the old module stays resident.
- R12: Two or more commands in the same cycle are all refused with code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| swap_go | input | 1 | Swap command pulse |
| swap_id | input | 2 | Module number for a swap |
| unload_go | input | 1 | Empty-the-slot command pulse |
| cancel_go | input | 1 | Withdraw a pending handshake |
| rm_req | output | 1 | Unload request to the resident module |
| rm_ack | input | 1 | Resident module has drained |
| isolate | output | 1 | Cut module outputs from the static side |
| feed_en | output | 1 | Static side may send data to the module |
| rm_rst | output | 1 | Reset to the new module |
| ld_valid | output | 1 | Loader command beat valid |
| ld_ready | input | 1 | Loader takes the beat |
| ld_word | output | CMD_W | Loader command beat |
| ld_done | input | 1 | Loader finished writing the image |
| slot_ready | output | 1 | Swap completed, module live |
| slot_loaded | output | 1 | A module is resident and initialised |
| slot_id | output | 2 | Number of the resident module |
| err_flag | output | 1 | One-cycle refusal or timeout pulse |
| err_code | output | 2 | 1 busy, 2 illegal, 3 timeout |

## Verification
Every state transition is one register stage, so each result is due a fixed number of cycles after its cause: `rm_req`, `ld_valid` and refusal pulses one cycle after the command, `isolate` one cycle after the acknowledge, reset RST_CYC cycles after the cycle following `ld_done`, and release plus ready one and two cycles after that; `feed_en` reacts to `rm_ack` in the same cycle. The bench drives and samples one nanosecond after the falling edge and counts cycles from each stimulus to land on those exact cycles. Loader beats are predicted into a queue when the command is issued and popped by a monitor on every handshake, with the loader throttled in some runs.

// File: rtl/slot_swap_pkg.sv
package slot_swap_pkg;
  localparam int ID_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_ISO,
    ST_LDCMD,
    ST_LDWAIT,
    ST_RST,
    ST_REL,
    ST_READY
  } swap_st_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_BUSY = 2'd1,
    ERR_BAD  = 2'd2,
    ERR_TMO  = 2'd3
  } err_e;
endpackage

// File: rtl/swap_cycle_cnt.sv
module swap_cycle_cnt #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic hit
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) cnt <= '0;
    else               cnt <= cnt + W'(1);
  end

  assign hit = en && (cnt == W'(LIMIT - 1));
endmodule

// File: rtl/swap_cmd_filter.sv
module swap_cmd_filter
  import slot_swap_pkg::*;
(
  input  swap_st_e st,
  input  logic     loaded,
  input  logic     rm_ack,
  input  logic     swap_go,
  input  logic     unload_go,
  input  logic     cancel_go,
  output logic     take_swap,
  output logic     take_unl,
  output logic     take_cancel,
  output err_e     rej
);
  logic [1:0] n_cmd;
  logic       idle_like;

  assign n_cmd     = {1'b0, swap_go} + {1'b0, unload_go} + {1'b0, cancel_go};
  assign idle_like = (st == ST_IDLE) || (st == ST_READY);

  always_comb begin
    take_swap   = 1'b0;
    take_unl    = 1'b0;
    take_cancel = 1'b0;
    rej         = ERR_NONE;
    if (n_cmd > 2'd1) begin
      rej = ERR_BAD;
    end else if (swap_go) begin
      if (idle_like) take_swap = 1'b1;
      else           rej = ERR_BUSY;
    end else if (unload_go) begin
      if (!idle_like)  rej = ERR_BUSY;
      else if (loaded) take_unl = 1'b1;
      else             rej = ERR_BAD;
    end else if (cancel_go) begin
      if (st == ST_SYNC && !rm_ack) take_cancel = 1'b1;
      else                          rej = ERR_BAD;
    end
  end
endmodule

// File: rtl/swap_load_issuer.sv
module swap_load_issuer
  import slot_swap_pkg::*;
#(
  parameter int CMD_W       = 32,
  parameter int BASE_STRIDE = 32'h4000,
  parameter int IMG_WORDS   = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [ID_W-1:0]  tgt_id,
  input  logic             ld_ready,
  output logic             ld_valid,
  output logic [CMD_W-1:0] ld_word,
  output logic             last_take
);
  localparam int PW = CMD_W - 2;

  logic [1:0]    beat;
  logic [PW-1:0] payload;
  logic          take;

  assign ld_valid  = active;
  assign take      = active && ld_ready;
  assign last_take = take && (beat == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n || !active) beat <= 2'd0;
    else if (take)         beat <= beat + 2'd1;
  end

  always_comb begin
    case (beat)
      2'd0:    payload = PW'(tgt_id);
      2'd1:    payload = PW'(BASE_STRIDE) * PW'(tgt_id);
      default: payload = PW'(IMG_WORDS);
    endcase
  end

  assign ld_word = {beat + 2'd1, payload};
endmodule

// File: rtl/swap_seq_fsm.sv
module swap_seq_fsm
  import slot_swap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_swap,
  input  logic            take_unl,
  input  logic            take_cancel,
  input  err_e            rej,
  input  logic [ID_W-1:0] swap_id,
  input  logic            rm_ack,
  input  logic            tmo_hit,
  input  logic            ld_last,
  input  logic            ld_done,
  input  logic            rst_hit,
  output swap_st_e        st,
  output logic            loaded,
  output logic [ID_W-1:0] cur_id,
  output logic [ID_W-1:0] tgt_id,
  output err_e            err_q
);
  logic unl_op;
  logic tmo_abort;

  assign tmo_abort = (st == ST_SYNC) && !rm_ack && !take_cancel && tmo_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      loaded <= 1'b0;
      cur_id <= '0;
      tgt_id <= '0;
      unl_op <= 1'b0;
      err_q  <= ERR_NONE;
    end else begin
      err_q <= tmo_abort ? ERR_TMO : rej;
      case (st)
        ST_IDLE, ST_READY: begin
          if (take_swap) begin
            tgt_id <= swap_id;
            unl_op <= 1'b0;
            st     <= loaded ? ST_SYNC : ST_LDCMD;
          end else if (take_unl) begin
            unl_op <= 1'b1;
            st     <= ST_SYNC;
          end
        end
        ST_SYNC: begin
          if (rm_ack)                      st <= ST_ISO;
          else if (take_cancel || tmo_hit) st <= ST_IDLE;
        end
        ST_ISO: begin
          loaded <= 1'b0;
          st     <= unl_op ? ST_IDLE : ST_LDCMD;
        end
        ST_LDCMD:  if (ld_last) st <= ST_LDWAIT;
        ST_LDWAIT: if (ld_done) st <= ST_RST;
        ST_RST:    if (rst_hit) st <= ST_REL;
        ST_REL: begin
          loaded <= 1'b1;
          cur_id <= tgt_id;
          st     <= ST_READY;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/slot_swap_ctrl.sv
module slot_swap_ctrl
  import slot_swap_pkg::*;
#(
  parameter int CMD_W       = 32,
  parameter int ACK_TMO     = 16,
  parameter int RST_CYC     = 4,
  parameter int BASE_STRIDE = 32'h4000,
  parameter int IMG_WORDS   = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             swap_go,
  input  logic [1:0]       swap_id,
  input  logic             unload_go,
  input  logic             cancel_go,
  output logic             rm_req,
  input  logic             rm_ack,
  output logic             isolate,
  output logic             feed_en,
  output logic             rm_rst,
  output logic             ld_valid,
  input  logic             ld_ready,
  output logic [CMD_W-1:0] ld_word,
  input  logic             ld_done,
  output logic             slot_ready,
  output logic             slot_loaded,
  output logic [1:0]       slot_id,
  output logic             err_flag,
  output logic [1:0]       err_code
);
  swap_st_e        st;
  logic            loaded;
  logic [ID_W-1:0] tgt_id;
  logic            take_swap, take_unl, take_cancel;
  err_e            rej, err_q;
  logic            tmo_hit, rst_hit, ld_last;

  swap_cmd_filter u_filter (
    .st(st), .loaded(loaded), .rm_ack(rm_ack),
    .swap_go(swap_go), .unload_go(unload_go), .cancel_go(cancel_go),
    .take_swap(take_swap), .take_unl(take_unl), .take_cancel(take_cancel),
    .rej(rej)
  );

  swap_cycle_cnt #(.LIMIT(ACK_TMO)) u_ack_wait (
    .clk(clk), .rst_n(rst_n), .en(st == ST_SYNC), .hit(tmo_hit)
  );

  swap_cycle_cnt #(.LIMIT(RST_CYC)) u_rst_hold (
    .clk(clk), .rst_n(rst_n), .en(st == ST_RST), .hit(rst_hit)
  );

  swap_load_issuer #(
    .CMD_W(CMD_W), .BASE_STRIDE(BASE_STRIDE), .IMG_WORDS(IMG_WORDS)
  ) u_issuer (
    .clk(clk), .rst_n(rst_n), .active(st == ST_LDCMD), .tgt_id(tgt_id),
    .ld_ready(ld_ready), .ld_valid(ld_valid), .ld_word(ld_word),
    .last_take(ld_last)
  );

  swap_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .take_swap(take_swap), .take_unl(take_unl), .take_cancel(take_cancel),
    .rej(rej), .swap_id(swap_id), .rm_ack(rm_ack), .tmo_hit(tmo_hit),
    .ld_last(ld_last), .ld_done(ld_done), .rst_hit(rst_hit),
    .st(st), .loaded(loaded), .cur_id(slot_id), .tgt_id(tgt_id), .err_q(err_q)
  );

  assign rm_req      = (st == ST_SYNC);
  assign rm_rst      = (st == ST_RST);
  assign isolate     = (st inside {ST_ISO, ST_LDCMD, ST_LDWAIT, ST_RST, ST_REL})
                    || (st == ST_IDLE && !loaded);
  assign feed_en     = loaded && ((st == ST_IDLE) || (st == ST_READY)
                    || (st == ST_SYNC && !rm_ack));
  assign slot_ready  = (st == ST_READY);
  assign slot_loaded = loaded;
  assign err_code    = err_q;
  assign err_flag    = (err_q != ERR_NONE);
endmodule

// File: rtl/slot_swap_chk.sv
module slot_swap_chk #(
  parameter int CMD_W   = 32,
  parameter int RST_CYC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rm_req,
  input logic             rm_ack,
  input logic             isolate,
  input logic             feed_en,
  input logic             rm_rst,
  input logic             ld_valid,
  input logic             ld_ready,
  input logic [CMD_W-1:0] ld_word,
  input logic             slot_ready,
  input logic [1:0]       err_code
);
  int run;

  always_ff @(posedge clk) begin
    if (!rst_n || !rm_rst) run <= 0;
    else                   run <= run + 1;
  end

  assert_no_feed_after_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rm_req && rm_ack) |-> !feed_en);

  assert_iso_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isolate) |-> $past(rm_req && rm_ack));

  assert_feed_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    feed_en |-> !isolate);

  assert_beat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !ld_ready) |=> (ld_valid && $stable(ld_word)));

  assert_rst_isolated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rm_rst |-> isolate);

  assert_rst_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rm_rst) |-> (run == RST_CYC));

  assert_release_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(isolate) |-> ($past(!rm_rst) && slot_ready));

  assert_tmo_no_iso_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code == 2'd3) |-> (!isolate && !rm_req));
endmodule

bind slot_swap_ctrl slot_swap_chk #(.CMD_W(CMD_W), .RST_CYC(RST_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .rm_req(rm_req), .rm_ack(rm_ack),
  .isolate(isolate), .feed_en(feed_en), .rm_rst(rm_rst),
  .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_word(ld_word),
  .slot_ready(slot_ready), .err_code(err_code)
);

// File: tb/slot_swap_ctrl_bench.sv
module slot_swap_ctrl_bench;
  localparam int CMD_W       = 32;
  localparam int ACK_TMO     = 16;
  localparam int RST_CYC     = 4;
  localparam int BASE_STRIDE = 32'h4000;
  localparam int IMG_WORDS   = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic swap_go = 1'b0, unload_go = 1'b0, cancel_go = 1'b0;
  logic [1:0] swap_id = 2'd0;
  logic rm_ack = 1'b0, ld_ready = 1'b0, ld_done = 1'b0;
  logic rm_req, isolate, feed_en, rm_rst, ld_valid, slot_ready, slot_loaded, err_flag;
  logic [CMD_W-1:0] ld_word;
  logic [1:0] slot_id, err_code;

  int n_chk = 0;
  int n_bad = 0;
  logic bp_mode = 1'b0;
  int bp_cnt = 0;
  logic [CMD_W-1:0] exp_q[$];

  always #4 clk = ~clk;

  slot_swap_ctrl #(
    .CMD_W(CMD_W), .ACK_TMO(ACK_TMO), .RST_CYC(RST_CYC),
    .BASE_STRIDE(BASE_STRIDE), .IMG_WORDS(IMG_WORDS)
  ) u_slot_swap_ctrl (
    .clk(clk), .rst_n(rst_n), .swap_go(swap_go), .swap_id(swap_id),
    .unload_go(unload_go), .cancel_go(cancel_go), .rm_req(rm_req),
    .rm_ack(rm_ack), .isolate(isolate), .feed_en(feed_en), .rm_rst(rm_rst),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_word(ld_word),
    .ld_done(ld_done), .slot_ready(slot_ready), .slot_loaded(slot_loaded),
    .slot_id(slot_id), .err_flag(err_flag), .err_code(err_code)
  );

  task automatic chk(input string tag, input logic [CMD_W-1:0] act, input logic [CMD_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  function automatic logic [CMD_W-1:0] beat_word(input int k, input logic [1:0] id);
    logic [CMD_W-3:0] p;
    if (k == 0)      p = (CMD_W-2)'(id);
    else if (k == 1) p = (CMD_W-2)'(int'(id) * BASE_STRIDE);
    else             p = (CMD_W-2)'(IMG_WORDS);
    return {2'(k + 1), p};
  endfunction

  task automatic push_burst(input logic [1:0] id);
    for (int k = 0; k < 3; k++) exp_q.push_back(beat_word(k, id));
  endtask

  // Monitor: owns ld_ready, pops one prediction per handshake
  initial begin
    forever begin
      @(negedge clk);
      ld_ready = bp_mode ? (bp_cnt % 3 == 2) : 1'b1;
      bp_cnt++;
      if (ld_valid && ld_ready) begin
        if (exp_q.size() == 0) chk("R4 unexpected beat", ld_valid, 1'b0);
        else                   chk("R4 beat word", ld_word, exp_q.pop_front());
      end
    end
  end

  // Common tail of a load: wait burst, loader done, reset window, release
  task automatic load_tail(input logic [1:0] id);
    int g = 0;
    while (exp_q.size() != 0 && g < 200) begin step(); g++; end
    chk("R4 burst drained", 32'(exp_q.size()), 32'd0);
    step();
    chk("R5 waiting loader, no beat", ld_valid, 1'b0);
    chk("R5 no reset before done", rm_rst, 1'b0);
    ld_done = 1'b1;
    step();
    ld_done = 1'b0;
    for (int i = 0; i < RST_CYC; i++) begin
      chk("R5 reset held", rm_rst, 1'b1);
      chk("R5 isolated in reset", isolate, 1'b1);
      step();
    end
    chk("R6 reset released", rm_rst, 1'b0);
    chk("R6 still isolated", isolate, 1'b1);
    chk("R6 not ready yet", slot_ready, 1'b0);
    step();
    chk("R6 isolation dropped", isolate, 1'b0);
    chk("R6 ready", slot_ready, 1'b1);
    chk("R6 loaded", slot_loaded, 1'b1);
    chk("R6 module id", slot_id, id);
    chk("R6 feed open", feed_en, 1'b1);
  endtask

  task automatic swap_from_empty(input logic [1:0] id);
    swap_go = 1'b1; swap_id = id; push_burst(id);
    step();
    swap_go = 1'b0;
    chk("R7 burst starts", ld_valid, 1'b1);
    chk("R7 no handshake", rm_req, 1'b0);
    chk("R7 isolated", isolate, 1'b1);
    load_tail(id);
  endtask

  initial begin
    repeat (3) step();
    chk("R1 isolate in reset", isolate, 1'b1);
    rst_n = 1'b1;
    step();
    chk("R1 isolate", isolate, 1'b1);
    chk("R1 empty", slot_loaded, 1'b0);
    chk("R1 req", rm_req, 1'b0);
    chk("R1 ld_valid", ld_valid, 1'b0);
    chk("R1 rm_rst", rm_rst, 1'b0);
    chk("R1 ready", slot_ready, 1'b0);
    chk("R1 feed", feed_en, 1'b0);
    chk("R1 err", err_flag, 1'b0);

    // R12: two commands at once
    swap_go = 1'b1; unload_go = 1'b1;
    step();
    swap_go = 1'b0; unload_go = 1'b0;
    chk("R12 code", err_code, 2'd2);
    chk("R12 nothing started", ld_valid | rm_req, 1'b0);
    step();
    chk("R12 pulse ends", err_flag, 1'b0);

    // R8: unload of empty slot
    unload_go = 1'b1;
    step();
    unload_go = 1'b0;
    chk("R8 empty unload refused", err_code, 2'd2);
    chk("R8 no handshake", rm_req, 1'b0);

    // R10: cancel with nothing pending
    cancel_go = 1'b1;
    step();
    cancel_go = 1'b0;
    chk("R10 idle cancel refused", err_code, 2'd2);

    // R7/R4/R5/R6 under back-pressure
    bp_mode = 1'b1;
    swap_from_empty(2'd2);
    bp_mode = 1'b0;

    // R5: stray loader done while ready
    ld_done = 1'b1;
    step();
    ld_done = 1'b0;
    chk("R5 stray done ignored", rm_rst, 1'b0);
    chk("R5 stray done still ready", slot_ready, 1'b1);

    // R2/R3/R9/R10: swap with resident module
    swap_go = 1'b1; swap_id = 2'd1; push_burst(2'd1);
    step();
    swap_go = 1'b0;
    chk("R2 req raised", rm_req, 1'b1);
    chk("R2 feed while waiting", feed_en, 1'b1);
    chk("R2 not isolated yet", isolate, 1'b0);
    swap_go = 1'b1; swap_id = 2'd0;
    step();
    swap_go = 1'b0;
    chk("R9 busy code", err_code, 2'd1);
    chk("R9 req kept", rm_req, 1'b1);
    step();
    chk("R9 pulse ends", err_flag, 1'b0);
    rm_ack = 1'b1; cancel_go = 1'b1;
    #1;
    chk("R2 feed stops on ack", feed_en, 1'b0);
    step();
    rm_ack = 1'b0; cancel_go = 1'b0;
    chk("R3 isolated after ack", isolate, 1'b1);
    chk("R3 req dropped", rm_req, 1'b0);
    chk("R10 late cancel refused", err_code, 2'd2);
    chk("R3 feed closed", feed_en, 1'b0);
    step();
    load_tail(2'd1);

    // R10: cancel before ack
    swap_go = 1'b1; swap_id = 2'd3;
    step();
    swap_go = 1'b0;
    chk("R10 req raised", rm_req, 1'b1);
    step();
    cancel_go = 1'b1;
    step();
    cancel_go = 1'b0;
    chk("R10 req dropped", rm_req, 1'b0);
    chk("R10 no isolation", isolate, 1'b0);
    chk("R10 no error", err_flag, 1'b0);
    chk("R10 still loaded", slot_loaded, 1'b1);
    chk("R10 old id kept", slot_id, 2'd1);
    chk("R10 feed open", feed_en, 1'b1);

    // R11: acknowledge never arrives
    swap_go = 1'b1; swap_id = 2'd0;
    step();
    swap_go = 1'b0;
    for (int i = 0; i < ACK_TMO; i++) begin
      chk("R11 req held", rm_req, 1'b1);
      chk("R11 not isolated", isolate, 1'b0);
      step();
    end
    chk("R11 req dropped", rm_req, 1'b0);
    chk("R11 timeout code", err_code, 2'd3);
    chk("R11 not isolated after", isolate, 1'b0);
    chk("R11 still loaded", slot_loaded, 1'b1);

    // R8: unload with resident module
    unload_go = 1'b1;
    step();
    unload_go = 1'b0;
    chk("R8 req raised", rm_req, 1'b1);
    rm_ack = 1'b1;
    step();
    rm_ack = 1'b0;
    chk("R8 isolated after ack", isolate, 1'b1);
    step();
    chk("R8 slot empty", slot_loaded, 1'b0);
    chk("R8 isolation kept", isolate, 1'b1);
    chk("R8 no burst", ld_valid, 1'b0);
    chk("R8 feed closed", feed_en, 1'b0);
    step();
    chk("R8 isolation still kept", isolate, 1'b1);

    // Reload after unload, throttled loader
    bp_mode = 1'b1;
    swap_from_empty(2'd3);
    bp_mode = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule